// File: doc/BRIEF.md
# Load Queue Ordering-Violation Detector

This block keeps the in-flight loads of one thread in a circular queue in program order. It holds each load's sequence number and, once the load has executed, the upper part of its effective address. When a store executes, the requester hands over the store address and the load-queue tail index that the store captured when it was allocated. The block then looks at every load younger than that store that has already executed. If one of them touched the same 256-byte region, the store was overtaken by that load. The block records the oldest such load as the violator and flags an ordering fault.

Loads enter through a valid/ready allocate port. A load offered while `alloc_ready` is low is not taken and must be held by the requester. The recorded violator leaves through a valid/ready port: `viol_valid` and `viol_idx` stay put until the consumer raises `viol_ready`, and the handshake clears the record. While a violator is held, later store checks skip the scan. Commit retires loads from the head. Squash removes loads from the tail. Address updates, store checks, commit and squash are plain strobes with no back-pressure.

Top module: `lq_order_guard`

## Requirements
- R1: After reset, `occupancy` is 0, `tail_idx` is 0, `alloc_ready` is 1, and `viol_valid`, `chk_done`, `chk_fault` and `viol_count` are 0.
- R2: A load is accepted when `alloc_valid` and `alloc_ready` are both high. It takes slot `tail_idx`, and after the edge `tail_idx` has advanced by one modulo CAP+1 and `occupancy` has grown by one. `alloc_ready` is low while `occupancy` equals CAP (tail plus one equals head). A load offered while full changes nothing.
- R3: A load matches a store when bits [31:8] of the two addresses are equal. Bits [7:0] are ignored, and any difference in bit 8 or above is not a match.
- R4: A load that has not received an address since it was allocated never matches. Allocation clears whatever address a reused slot held before.
- R5: A check covers only the slots from `chk_start` (inclusive) forward to `tail_idx` (exclusive), wrapping from CAP back to 0. When `chk_start` equals `tail_idx`, no slot is checked.
- R6: The edge after an accepted check raises `chk_done` for one cycle. If any covered load matches, it also raises `chk_fault` for one cycle, sets `viol_valid`, increments `viol_count` by one, and sets `viol_idx` to the matching slot nearest `chk_start` in the forward direction.
- R7: While `viol_valid` is high, an accepted check yields `chk_done`=1 and `chk_fault`=0, and leaves `viol_idx` and `viol_count` unchanged. A cycle with `viol_valid` and `viol_ready` both high clears `viol_valid` at the edge.
- R8: A commit strobe retires loads from the head for as long as the queue is non-empty and the head load's sequence number is at most `commit_seq`. `occupancy` drops by that number after the edge.
- R9: A squash strobe removes loads from the tail backward for as long as the queue is non-empty and the tail-most load's sequence number exceeds `squash_seq`. In a squash cycle, `alloc_ready` is low, and any commit or store check is ignored (no `chk_done` follows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A new load is offered |
| alloc_ready | output | 1 | Queue can take a load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the offered load |
| tail_idx | output | IDX_W | Slot the next load will take; stores capture it |
| addr_valid | input | 1 | A load has executed |
| addr_idx | input | IDX_W | Slot of the executed load |
| addr_value | input | ADDR_W | Effective address of the executed load |
| chk_valid | input | 1 | A store executes and requests a check |
| chk_start | input | IDX_W | Load tail captured by the store at allocation |
| chk_addr | input | ADDR_W | Effective address of the store |
| chk_done | output | 1 | Pulse: a check finished |
| chk_fault | output | 1 | Pulse: that check found a violation |
| commit_valid | input | 1 | Commit broadcast strobe |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| viol_valid | output | 1 | A violator is recorded |
| viol_ready | input | 1 | Consumer takes the violator and clears it |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_count | output | CNT_W | Number of violations found, wrapping |
| occupancy | output | IDX_W | Number of loads in the queue |

## Verification
`alloc_ready` is combinational, so the bench reads it in the same cycle as the stimulus that affects it. `tail_idx` and `occupancy` move at the first rising edge after an allocate, commit or squash. `chk_done`, `chk_fault`, `viol_valid`, `viol_idx` and `viol_count` appear at the first rising edge after a check, and `viol_valid` falls at the first edge after the read handshake. The bench therefore drives every stimulus on a falling edge and compares at the next falling edge, which lies exactly one register stage later. It sweeps every start index of the 8-slot ring against several probe addresses, and a small queue model in the bench predicts the result of each check.

// File: rtl/lqv_pkg.sv
package lqv_pkg;
  // Outcome of one store check, as registered for the next cycle.
  typedef enum logic [1:0] {
    CHK_NONE  = 2'd0,
    CHK_CLEAN = 2'd1,
    CHK_HIT   = 2'd2,
    CHK_SKIP  = 2'd3
  } chk_res_e;
endpackage

// File: rtl/lqv_run_len.sv
// Length of the run of passing slots from a start slot, walking forward
// or backward around the ring, limited to the live entries.
module lqv_run_len #(
  parameter int DEPTH = 8,
  parameter bit BACKWARD = 1'b0,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    start,
  input  logic [IW-1:0]    live,
  input  logic [DEPTH-1:0] pass,
  output logic [IW-1:0]    len
);
  always_comb begin
    logic run;
    int   pos;
    len = '0;
    run = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      if (BACKWARD) pos = (int'(start) + DEPTH - k) % DEPTH;
      else          pos = (int'(start) + k) % DEPTH;
      if (run && (k < int'(live)) && pass[pos]) len = len + 1'b1;
      else                                      run = 1'b0;
    end
  end
endmodule

// File: rtl/lqv_scan.sv
// Wrap-aware range mask from start to tail, region compare, and selection
// of the matching slot nearest the start.
module lqv_scan #(
  parameter int DEPTH = 8,
  parameter int RW = 24,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    start,
  input  logic [IW-1:0]    tail,
  input  logic [DEPTH-1:0] armed,
  input  logic [RW-1:0]    region [DEPTH],
  input  logic [RW-1:0]    probe,
  output logic             hit,
  output logic [IW-1:0]    hit_idx
);
  int span;
  logic [DEPTH-1:0] in_range;
  logic [DEPTH-1:0] match;

  assign span = (int'(tail) + DEPTH - int'(start)) % DEPTH;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign in_range[i] = ((i + DEPTH - int'(start)) % DEPTH) < span;
    assign match[i]    = in_range[i] && armed[i] && (region[i] == probe);
  end

  always_comb begin
    int pos;
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = (int'(start) + k) % DEPTH;
      if (!hit && match[pos]) begin
        hit     = 1'b1;
        hit_idx = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/lq_order_guard.sv
module lq_order_guard
  import lqv_pkg::*;
#(
  parameter int CAP = 7,
  parameter int ADDR_W = 32,
  parameter int SEQ_W = 16,
  parameter int REGION_SHIFT = 8,
  parameter int CNT_W = 16,
  localparam int DEPTH = CAP + 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RW = ADDR_W - REGION_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  tail_idx,
  input  logic              addr_valid,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_start,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_done,
  output logic              chk_fault,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              viol_valid,
  input  logic              viol_ready,
  output logic [IDX_W-1:0]  viol_idx,
  output logic [CNT_W-1:0]  viol_count,
  output logic [IDX_W-1:0]  occupancy
);
  // Slot storage: sequence numbers and address regions need no reset,
  // the armed bits tell whether a region is meaningful.
  logic [SEQ_W-1:0] seq_q    [DEPTH];
  logic [RW-1:0]    region_q [DEPTH];
  logic [DEPTH-1:0] armed_q;

  logic [IDX_W-1:0] head_q, tail_q, occ_q;
  logic [IDX_W-1:0] head_n, tail_n, occ_n;
  logic             vv_q;
  logic [IDX_W-1:0] vidx_q;
  logic [CNT_W-1:0] cnt_q;
  chk_res_e         res_q, res_n;

  logic             alloc_fire, chk_take;
  logic [DEPTH-1:0] old_enough, too_young;
  logic [IDX_W-1:0] ret_len, sq_len, sq_start;
  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;

  assign alloc_ready = (occ_q != IDX_W'(CAP)) && !squash_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign chk_take    = chk_valid && !squash_valid;
  assign sq_start    = IDX_W'((int'(tail_q) + DEPTH - 1) % DEPTH);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      old_enough[i] = (seq_q[i] <= commit_seq);
      too_young[i]  = (seq_q[i] > squash_seq);
    end
  end

  lqv_run_len #(.DEPTH(DEPTH), .BACKWARD(1'b0)) u_commit_run (
    .start(head_q), .live(occ_q), .pass(old_enough), .len(ret_len)
  );

  lqv_run_len #(.DEPTH(DEPTH), .BACKWARD(1'b1)) u_squash_run (
    .start(sq_start), .live(occ_q), .pass(too_young), .len(sq_len)
  );

  lqv_scan #(.DEPTH(DEPTH), .RW(RW)) u_scan (
    .start(chk_start), .tail(tail_q), .armed(armed_q), .region(region_q),
    .probe(chk_addr[ADDR_W-1:REGION_SHIFT]), .hit(scan_hit), .hit_idx(scan_idx)
  );

  // Pointer and occupancy update: squash wins over commit and allocate.
  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    occ_n  = occ_q;
    if (squash_valid) begin
      occ_n  = occ_q - sq_len;
      tail_n = IDX_W'((int'(tail_q) + DEPTH - int'(sq_len)) % DEPTH);
    end else begin
      if (commit_valid) begin
        occ_n  = occ_n - ret_len;
        head_n = IDX_W'((int'(head_q) + int'(ret_len)) % DEPTH);
      end
      if (alloc_fire) begin
        occ_n  = occ_n + 1'b1;
        tail_n = IDX_W'((int'(tail_q) + 1) % DEPTH);
      end
    end
  end

  always_comb begin
    if (!chk_take)    res_n = CHK_NONE;
    else if (vv_q)    res_n = CHK_SKIP;
    else if (scan_hit) res_n = CHK_HIT;
    else              res_n = CHK_CLEAN;
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) seq_q[tail_q] <= alloc_seq;
    if (addr_valid) region_q[addr_idx] <= addr_value[ADDR_W-1:REGION_SHIFT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      occ_q   <= '0;
      vv_q    <= 1'b0;
      vidx_q  <= '0;
      cnt_q   <= '0;
      res_q   <= CHK_NONE;
    end else begin
      if (addr_valid) armed_q[addr_idx] <= 1'b1;
      if (alloc_fire) armed_q[tail_q] <= 1'b0;
      head_q <= head_n;
      tail_q <= tail_n;
      occ_q  <= occ_n;
      res_q  <= res_n;
      if (res_n == CHK_HIT) begin
        vv_q   <= 1'b1;
        vidx_q <= scan_idx;
        cnt_q  <= cnt_q + 1'b1;
      end else if (vv_q && viol_ready) begin
        vv_q <= 1'b0;
      end
    end
  end

  assign tail_idx   = tail_q;
  assign occupancy  = occ_q;
  assign viol_valid = vv_q;
  assign viol_idx   = vidx_q;
  assign viol_count = cnt_q;
  assign chk_done   = (res_q != CHK_NONE);
  assign chk_fault  = (res_q == CHK_HIT);
endmodule

// File: rtl/lqv_checker.sv
module lqv_checker #(
  parameter int CAP = 7,
  parameter int IDX_W = 3,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] tail_idx,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] occupancy,
  input logic             chk_done,
  input logic             chk_fault,
  input logic             squash_valid,
  input logic             viol_valid,
  input logic             viol_ready,
  input logic [IDX_W-1:0] viol_idx,
  input logic [CNT_W-1:0] viol_count
);
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= IDX_W'(CAP));
  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == IDX_W'(CAP)) |-> !alloc_ready);
  // R2
  ring_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(head) + int'(occupancy)) % (CAP + 1)) == int'(tail_idx));
  // R6
  fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (chk_done && viol_valid));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (viol_count == $past(viol_count) + 1'b1));
  // R7
  hold_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_ready) |=> (viol_valid && $stable(viol_idx)));
  // R7
  skip_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |=> !chk_fault);
  // R9
  squash_nochk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !chk_done);
  // R9
  squash_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> !alloc_ready);
endmodule

bind lq_order_guard lqv_checker #(.CAP(CAP), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lqv_checker (
  .clk(clk), .rst_n(rst_n), .alloc_ready(alloc_ready), .tail_idx(tail_idx),
  .head(head_q), .occupancy(occupancy), .chk_done(chk_done), .chk_fault(chk_fault),
  .squash_valid(squash_valid), .viol_valid(viol_valid), .viol_ready(viol_ready),
  .viol_idx(viol_idx), .viol_count(viol_count)
);

// File: tb/lq_order_guard_test.sv
module lq_order_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 7;
  localparam int DEPTH = CAP + 1;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [15:0] alloc_seq = '0;
  logic [2:0]  tail_idx;
  logic        addr_valid = 1'b0;
  logic [2:0]  addr_idx = '0;
  logic [31:0] addr_value = '0;
  logic        chk_valid = 1'b0;
  logic [2:0]  chk_start = '0;
  logic [31:0] chk_addr = '0;
  logic        chk_done, chk_fault;
  logic        commit_valid = 1'b0;
  logic [15:0] commit_seq = '0;
  logic        squash_valid = 1'b0;
  logic [15:0] squash_seq = '0;
  logic        viol_valid;
  logic        viol_ready = 1'b0;
  logic [2:0]  viol_idx;
  logic [15:0] viol_count;
  logic [2:0]  occupancy;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lq_order_guard uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_seq(alloc_seq), .tail_idx(tail_idx), .addr_valid(addr_valid),
    .addr_idx(addr_idx), .addr_value(addr_value), .chk_valid(chk_valid),
    .chk_start(chk_start), .chk_addr(chk_addr), .chk_done(chk_done),
    .chk_fault(chk_fault), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .viol_valid(viol_valid),
    .viol_ready(viol_ready), .viol_idx(viol_idx), .viol_count(viol_count),
    .occupancy(occupancy)
  );

  int checks = 0;
  int errors = 0;

  // Bench queue model, written from the requirements.
  int   m_head = 0, m_tail = 0, m_occ = 0, m_cnt = 0, m_vi = 0;
  bit   m_vv = 1'b0;
  int   m_seq [DEPTH];
  bit   m_arm [DEPTH];
  int   m_reg [DEPTH];

  task automatic expect_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_alloc(int seq);
    bit take;
    take = (m_occ < CAP);
    expect_eq("R2 alloc_ready", alloc_ready, take);
    expect_eq("R2 slot offered", tail_idx, m_tail);
    alloc_valid = 1'b1;
    alloc_seq = 16'(seq);
    @(negedge clk);
    alloc_valid = 1'b0;
    if (take) begin
      m_seq[m_tail] = seq;
      m_arm[m_tail] = 1'b0;
      m_tail = (m_tail + 1) % DEPTH;
      m_occ++;
    end
    expect_eq("R2 occupancy", occupancy, m_occ);
    expect_eq("R2 tail advance", tail_idx, m_tail);
  endtask

  task automatic do_addr(int idx, logic [31:0] a);
    addr_valid = 1'b1;
    addr_idx = 3'(idx);
    addr_value = a;
    @(negedge clk);
    addr_valid = 1'b0;
    m_arm[idx] = 1'b1;
    m_reg[idx] = int'(a >> 8);
  endtask

  task automatic do_check(int start, logic [31:0] a, string tag);
    bit exp_fault;
    int span;
    exp_fault = 1'b0;
    if (!m_vv) begin
      span = (m_tail + DEPTH - start) % DEPTH;
      for (int k = 0; k < span; k++) begin
        int pos;
        pos = (start + k) % DEPTH;
        if (!exp_fault && m_arm[pos] && m_reg[pos] == int'(a >> 8)) begin
          exp_fault = 1'b1;
          m_vi = pos;
        end
      end
      if (exp_fault) begin
        m_vv = 1'b1;
        m_cnt++;
      end
    end
    chk_valid = 1'b1;
    chk_start = 3'(start);
    chk_addr = a;
    @(negedge clk);
    chk_valid = 1'b0;
    expect_eq({tag, " R6 done"}, chk_done, 1);
    expect_eq({tag, " fault"}, chk_fault, exp_fault);
    expect_eq({tag, " R6 viol_valid"}, viol_valid, m_vv);
    if (m_vv) expect_eq({tag, " R6 viol_idx"}, viol_idx, m_vi);
    expect_eq({tag, " R6 count"}, viol_count, m_cnt);
  endtask

  task automatic do_read();
    viol_ready = 1'b1;
    @(negedge clk);
    viol_ready = 1'b0;
    m_vv = 1'b0;
    expect_eq("R7 cleared by read", viol_valid, 0);
  endtask

  task automatic do_commit(int y);
    while (m_occ > 0 && m_seq[m_head] <= y) begin
      m_head = (m_head + 1) % DEPTH;
      m_occ--;
    end
    commit_valid = 1'b1;
    commit_seq = 16'(y);
    @(negedge clk);
    commit_valid = 1'b0;
    expect_eq("R8 occupancy after commit", occupancy, m_occ);
    expect_eq("R8 alloc_ready after commit", alloc_ready, m_occ < CAP);
  endtask

  // Squash with a competing allocate and store check in the same cycle.
  task automatic do_squash(int s, int start, logic [31:0] a);
    int occ_before;
    occ_before = m_occ;
    while (m_occ > 0 && m_seq[(m_tail + DEPTH - 1) % DEPTH] > s) begin
      m_tail = (m_tail + DEPTH - 1) % DEPTH;
      m_occ--;
    end
    squash_valid = 1'b1;
    squash_seq = 16'(s);
    alloc_valid = 1'b1;
    alloc_seq = 16'(500);
    chk_valid = 1'b1;
    chk_start = 3'(start);
    chk_addr = a;
    #1;
    expect_eq("R9 alloc_ready low in squash", alloc_ready, 0);
    @(negedge clk);
    squash_valid = 1'b0;
    alloc_valid = 1'b0;
    chk_valid = 1'b0;
    expect_eq("R9 occupancy after squash", occupancy, m_occ);
    expect_eq("R9 tail after squash", tail_idx, m_tail);
    expect_eq("R9 check ignored", chk_done, 0);
    expect_eq("R9 count unchanged", viol_count, m_cnt);
    if (occ_before == m_occ) $display("note: squash removed nothing");
  endtask

  localparam logic [31:0] RA = 32'h1234_5610;
  localparam logic [31:0] RB = 32'h0000_7780;
  localparam logic [31:0] RC = 32'hFFFF_FF00;

  initial begin
    logic [31:0] probes [5];
    probes[0] = 32'h1234_56FF;  // region of RA, other low byte
    probes[1] = 32'h0000_7701;  // region of RB
    probes[2] = RC;
    probes[3] = 32'h1234_5710;  // differs from RA in bit 8
    probes[4] = 32'h0000_0042;  // matches no armed load
    for (int i = 0; i < DEPTH; i++) begin
      m_seq[i] = 0;
      m_arm[i] = 1'b0;
      m_reg[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq("R1 occupancy", occupancy, 0);
    expect_eq("R1 tail_idx", tail_idx, 0);
    expect_eq("R1 alloc_ready", alloc_ready, 1);
    expect_eq("R1 viol_valid", viol_valid, 0);
    expect_eq("R1 chk_done", chk_done, 0);
    expect_eq("R1 chk_fault", chk_fault, 0);
    expect_eq("R1 viol_count", viol_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: fill to capacity, then offer one more
    for (int i = 0; i < CAP; i++) do_alloc(10 + i);
    do_alloc(99);

    // Slot 0 stays unexecuted (R4); others receive regions
    do_addr(1, 32'h0000_0A00);
    do_addr(2, RA);
    do_addr(3, RB);
    do_addr(4, 32'h1234_5680);
    do_addr(5, RC);
    do_addr(6, 32'h0000_77F0);

    // R3 R5 R6: every start index against every probe
    for (int st = 0; st < DEPTH; st++) begin
      for (int p = 0; p < 5; p++) begin
        do_check(st, probes[p], "R3 R5 sweep");
        if (m_vv) do_read();
      end
    end
    do_check(0, 32'h0000_0000, "R4 unexecuted slot 0");

    // R7: a held violator blocks the next scan
    do_check(0, RA, "R7 first hit");
    do_check(0, RB, "R7 skipped scan");
    expect_eq("R7 idx kept", viol_idx, 2);
    do_read();

    // R8: commit below head retires none, then three
    do_commit(9);
    do_commit(12);

    // Wrap: slots 7, 0, 1 reused; slot 1 loses its old region
    do_alloc(17);
    do_alloc(18);
    do_alloc(19);
    do_check(7, 32'h0000_0A55, "R4 reused slot cleared");
    do_addr(0, RA);
    do_check(6, RA, "R5 wrap hit");
    do_read();

    // R9: squash removes 19 and 18, check and alloc in same cycle ignored
    do_squash(17, 3, RA);
    do_check(3, RA, "R9 after squash");
    do_read();
    do_squash(0, 0, RB);
    expect_eq("R9 empty after full squash", occupancy, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule